// File: doc/BRIEF.md
# Home-Node Compare-and-Swap Handler

This block sits at the home node of a directory-based coherent memory and services compare-and-swap requests from remote caches that do not already hold the target line exclusively. It keeps a small directory, with a state and a holder bit mask for each line, plus the home copy of each line's value. For every request it takes the most current value of the line, compares it with the requester's expected value and decides whether to grant.

On a match, the requester becomes the sole exclusive holder and the new value is installed. Every other holder is invalidated, and the success response is held back until each invalidation has been acknowledged. On a mismatch, no other cache ever loses its copy. A build-time mode chooses between two failure policies. In deny mode, the requester gets a failure and nothing else. In share mode, it gets a failure together with a read-only copy. When the line is held exclusive by another node, the handler first asks that owner to send its data back, then compares. Depending on the outcome it invalidates the owner, downgrades it to read-only, or leaves it alone.

The handler runs one transaction at a time. A request to the line being worked on is bounced at once with a busy response. A request to any other line is held off until the transaction finishes.

Top module: `casHomeNode`

## Requirements
- R1: After reset every line is uncached with home value zero, reqReady is high, and rspValid, invValid and fetchValid are low.
- R2: For a line that is uncached or shared, the expected value is compared with the home value, and the response returns that home value in rspOld.
- R3: For a line held exclusive by another node, one fetch-back (fetchValid with fetchNode equal to the owner and fetchLine equal to the line) is issued, and the comparison uses the data returned on wbData. That data is returned in rspOld.
- R4: On a match the response has rspSuccess=1 and rspGrant=2 (exclusive). The requester becomes the only holder, and the new value is the line's value from then on.
- R5: On a match every other holder of the line, and only those, receives exactly one message with invDowngrade=0. The requester never receives one.
- R6: A success response is issued only after one ackValid pulse has been received for every message sent on the invalidation channel.
- R7: In deny mode (FAIL_SHARE=0) a mismatch gives rspSuccess=0 and rspGrant=0 (none). No message is sent on the invalidation channel, and the line's state, holders and value are left unchanged.
- R8: In share mode (FAIL_SHARE=1) a mismatch gives rspSuccess=0 and rspGrant=1 (shared), and the requester is added to the holders. No copy is invalidated. An exclusive owner is instead sent one message with invDowngrade=1, and its returned data becomes the home value.
- R9: A request to the line of the transaction in flight is consumed in the cycle it is presented, with rspValid=1, rspBusy=1, rspSuccess=0 and rspGrant=0, and it does not change that transaction's outcome.
- R10: While a transaction is in flight, reqReady is low for a request to any other line. Only one transaction is ever in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken this cycle |
| reqNode | input | NODE_W | Requesting node |
| reqLine | input | LINE_W | Target line |
| reqExpect | input | DATA_W | Expected value |
| reqNew | input | DATA_W | Value to install on a match |
| rspValid | output | 1 | Response present (one cycle) |
| rspBusy | output | 1 | Response is a busy bounce |
| rspSuccess | output | 1 | Compare matched |
| rspGrant | output | 2 | 0 none, 1 shared, 2 exclusive |
| rspNode | output | NODE_W | Node the response goes to |
| rspOld | output | DATA_W | Value the comparison used |
| fetchValid | output | 1 | Fetch-back request to the owner |
| fetchNode | output | NODE_W | Owner node |
| fetchLine | output | LINE_W | Line fetched |
| wbValid | input | 1 | Owner data returned |
| wbData | input | DATA_W | Owner data |
| invValid | output | 1 | Invalidate or downgrade message |
| invNode | output | NODE_W | Target node |
| invLine | output | LINE_W | Target line |
| invDowngrade | output | 1 | 1 keep a read-only copy, 0 drop the copy |
| ackValid | input | 1 | One acknowledgement of a message |

## Verification
The assertions assume the surrounding caches behave correctly. A node never requests a line it already owns exclusively. wbValid comes only once, after a fetch-back. Each invalidation or downgrade message gets exactly one ackValid, and acknowledgements never arrive unsolicited. The bench acts as those caches. It returns owner data a few cycles after each fetch-back, acknowledges each message two cycles after seeing it, and only sends requests that respect these rules. Busy and other-line requests are injected only while a fetch-back is outstanding, so they are known to overlap a transaction in flight.

// File: rtl/casPkg.sv
package casPkg;

  typedef enum logic [1:0] {
    LINE_UNC = 2'd0,
    LINE_SHR = 2'd1,
    LINE_EXC = 2'd2
  } lineStateT;

  typedef enum logic [1:0] {
    GRANT_NONE = 2'd0,
    GRANT_SHR  = 2'd1,
    GRANT_EXC  = 2'd2
  } grantT;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;
    logic busyRsp;
    logic sendFetch;
    logic decideHome;
    logic decideOwner;
    logic drain;
    logic commit;
  } casStrobeT;

endpackage

// File: rtl/casControl.sv
module casControl
  import casPkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [LINE_W-1:0] curLine,
  input  logic              lineIsExc,
  input  logic              wbValid,
  input  logic              drainDone,
  output logic              reqReady,
  output casStrobeT         strobe
);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVAL  = 3'd1,
    ST_FETCH = 3'd2,
    ST_DRAIN = 3'd3,
    ST_RESP  = 3'd4
  } stateT;

  stateT state, stateNext;
  logic  sameLine;

  assign sameLine = (reqLine == curLine);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady      = 1'b1;
        strobe.accept = reqValid;
        if (reqValid) stateNext = ST_EVAL;
      end
      ST_EVAL: begin
        reqReady       = sameLine;
        strobe.busyRsp = reqValid && sameLine;
        if (lineIsExc) begin
          strobe.sendFetch = 1'b1;
          stateNext        = ST_FETCH;
        end else begin
          strobe.decideHome = 1'b1;
          stateNext         = ST_DRAIN;
        end
      end
      ST_FETCH: begin
        reqReady       = sameLine;
        strobe.busyRsp = reqValid && sameLine;
        if (wbValid) begin
          strobe.decideOwner = 1'b1;
          stateNext          = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        reqReady       = sameLine;
        strobe.busyRsp = reqValid && sameLine;
        strobe.drain   = 1'b1;
        if (drainDone) stateNext = ST_RESP;
      end
      ST_RESP: begin
        strobe.commit = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/casDatapath.sv
module casDatapath
  import casPkg::*;
#(
  parameter int NUM_NODES  = 4,
  parameter int NUM_LINES  = 8,
  parameter int DATA_W     = 16,
  parameter int FAIL_SHARE = 0,
  localparam int NODE_W    = $clog2(NUM_NODES),
  localparam int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  casStrobeT         strobe,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [DATA_W-1:0] reqExpect,
  input  logic [DATA_W-1:0] reqNew,
  input  logic [DATA_W-1:0] wbData,
  input  logic              ackValid,
  output logic [LINE_W-1:0] curLine,
  output logic              lineIsExc,
  output logic              drainDone,
  output logic              rspValid,
  output logic              rspBusy,
  output logic              rspSuccess,
  output logic [1:0]        rspGrant,
  output logic [NODE_W-1:0] rspNode,
  output logic [DATA_W-1:0] rspOld,
  output logic              fetchValid,
  output logic [NODE_W-1:0] fetchNode,
  output logic [LINE_W-1:0] fetchLine,
  output logic              invValid,
  output logic [NODE_W-1:0] invNode,
  output logic [LINE_W-1:0] invLine,
  output logic              invDowngrade
);

  localparam int CNT_W = NODE_W + 1;

  // transaction registers
  logic [NODE_W-1:0]    nodeQ;
  logic [LINE_W-1:0]    lineQ;
  logic [DATA_W-1:0]    expectQ, newQ, oldQ, memDataQ;
  logic                 succQ, downQ, memWrQ;
  grantT                grantQ;
  lineStateT            nextSt;
  logic [NUM_NODES-1:0] nextMask, pendMask;
  logic [CNT_W-1:0]     ackCnt;

  // per-line read views
  lineStateT            stVec   [NUM_LINES];
  logic [NUM_NODES-1:0] maskVec [NUM_LINES];
  logic [DATA_W-1:0]    valVec  [NUM_LINES];

  lineStateT            curSt;
  logic [NUM_NODES-1:0] curMask, reqBit, lowBit;
  logic [DATA_W-1:0]    cmpVal;
  logic                 isMatch, decide, issueInv;

  function automatic logic [NODE_W-1:0] firstSet(input logic [NUM_NODES-1:0] m);
    logic [NODE_W-1:0] r;
    r = '0;
    for (int i = NUM_NODES - 1; i >= 0; i--) begin
      if (m[i]) r = NODE_W'(i);
    end
    return r;
  endfunction

  // directory entry and home value per line
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    lineStateT            st;
    logic [NUM_NODES-1:0] holders;
    logic [DATA_W-1:0]    val;
    logic                 hit;

    assign hit = strobe.commit && (lineQ == LINE_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st      <= LINE_UNC;
        holders <= '0;
        val     <= '0;
      end else if (hit) begin
        st      <= nextSt;
        holders <= nextMask;
        if (memWrQ) val <= memDataQ;
      end
    end

    assign stVec[g]   = st;
    assign maskVec[g] = holders;
    assign valVec[g]  = val;
  end

  assign curSt     = stVec[lineQ];
  assign curMask   = maskVec[lineQ];
  assign cmpVal    = strobe.decideOwner ? wbData : valVec[lineQ];
  assign isMatch   = (cmpVal == expectQ);
  assign reqBit    = NUM_NODES'(1) << nodeQ;
  assign lowBit    = pendMask & (~pendMask + NUM_NODES'(1));
  assign decide    = strobe.decideHome | strobe.decideOwner;
  assign issueInv  = strobe.drain && (pendMask != '0);
  assign curLine   = lineQ;
  assign lineIsExc = (curSt == LINE_EXC);
  assign drainDone = (pendMask == '0) && (ackCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nodeQ   <= '0;
      lineQ   <= '0;
      expectQ <= '0;
      newQ    <= '0;
    end else if (strobe.accept) begin
      nodeQ   <= reqNode;
      lineQ   <= reqLine;
      expectQ <= reqExpect;
      newQ    <= reqNew;
    end
  end

  // outcome decision and invalidation issue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oldQ     <= '0;
      succQ    <= 1'b0;
      grantQ   <= GRANT_NONE;
      pendMask <= '0;
      downQ    <= 1'b0;
      nextSt   <= LINE_UNC;
      nextMask <= '0;
      memWrQ   <= 1'b0;
      memDataQ <= '0;
    end else if (decide) begin
      oldQ <= cmpVal;
      if (isMatch) begin
        succQ    <= 1'b1;
        grantQ   <= GRANT_EXC;
        pendMask <= curMask & ~reqBit;
        downQ    <= 1'b0;
        nextSt   <= LINE_EXC;
        nextMask <= reqBit;
        memWrQ   <= 1'b1;
        memDataQ <= newQ;
      end else if (FAIL_SHARE != 0) begin
        succQ    <= 1'b0;
        grantQ   <= GRANT_SHR;
        pendMask <= strobe.decideOwner ? curMask : '0;
        downQ    <= 1'b1;
        nextSt   <= LINE_SHR;
        nextMask <= curMask | reqBit;
        memWrQ   <= strobe.decideOwner;
        memDataQ <= cmpVal;
      end else begin
        succQ    <= 1'b0;
        grantQ   <= GRANT_NONE;
        pendMask <= '0;
        downQ    <= 1'b0;
        nextSt   <= curSt;
        nextMask <= curMask;
        memWrQ   <= 1'b0;
        memDataQ <= cmpVal;
      end
    end else if (issueInv) begin
      pendMask <= pendMask & ~lowBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackCnt <= '0;
    else       ackCnt <= ackCnt + CNT_W'(issueInv) - CNT_W'(ackValid);
  end

  assign fetchValid   = strobe.sendFetch;
  assign fetchNode    = firstSet(curMask);
  assign fetchLine    = lineQ;
  assign invValid     = issueInv;
  assign invNode      = firstSet(lowBit);
  assign invLine      = lineQ;
  assign invDowngrade = downQ;

  always_comb begin
    rspValid   = strobe.commit | strobe.busyRsp;
    rspBusy    = 1'b0;
    rspSuccess = 1'b0;
    rspGrant   = GRANT_NONE;
    rspNode    = reqNode;
    rspOld     = '0;
    if (strobe.commit) begin
      rspSuccess = succQ;
      rspGrant   = grantQ;
      rspNode    = nodeQ;
      rspOld     = oldQ;
    end else if (strobe.busyRsp) begin
      rspBusy = 1'b1;
    end
  end

endmodule

// File: rtl/casHomeNode.sv
module casHomeNode
  import casPkg::*;
#(
  parameter int NUM_NODES  = 4,
  parameter int NUM_LINES  = 8,
  parameter int DATA_W     = 16,
  parameter int FAIL_SHARE = 0,
  localparam int NODE_W    = $clog2(NUM_NODES),
  localparam int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [DATA_W-1:0] reqExpect,
  input  logic [DATA_W-1:0] reqNew,
  output logic              rspValid,
  output logic              rspBusy,
  output logic              rspSuccess,
  output logic [1:0]        rspGrant,
  output logic [NODE_W-1:0] rspNode,
  output logic [DATA_W-1:0] rspOld,
  output logic              fetchValid,
  output logic [NODE_W-1:0] fetchNode,
  output logic [LINE_W-1:0] fetchLine,
  input  logic              wbValid,
  input  logic [DATA_W-1:0] wbData,
  output logic              invValid,
  output logic [NODE_W-1:0] invNode,
  output logic [LINE_W-1:0] invLine,
  output logic              invDowngrade,
  input  logic              ackValid
);

  casStrobeT         strobe;
  logic [LINE_W-1:0] curLine;
  logic              lineIsExc;
  logic              drainDone;

  casControl #(.LINE_W(LINE_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqLine   (reqLine),
    .curLine   (curLine),
    .lineIsExc (lineIsExc),
    .wbValid   (wbValid),
    .drainDone (drainDone),
    .reqReady  (reqReady),
    .strobe    (strobe)
  );

  casDatapath #(
    .NUM_NODES  (NUM_NODES),
    .NUM_LINES  (NUM_LINES),
    .DATA_W     (DATA_W),
    .FAIL_SHARE (FAIL_SHARE)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqNode      (reqNode),
    .reqLine      (reqLine),
    .reqExpect    (reqExpect),
    .reqNew       (reqNew),
    .wbData       (wbData),
    .ackValid     (ackValid),
    .curLine      (curLine),
    .lineIsExc    (lineIsExc),
    .drainDone    (drainDone),
    .rspValid     (rspValid),
    .rspBusy      (rspBusy),
    .rspSuccess   (rspSuccess),
    .rspGrant     (rspGrant),
    .rspNode      (rspNode),
    .rspOld       (rspOld),
    .fetchValid   (fetchValid),
    .fetchNode    (fetchNode),
    .fetchLine    (fetchLine),
    .invValid     (invValid),
    .invNode      (invNode),
    .invLine      (invLine),
    .invDowngrade (invDowngrade)
  );

endmodule

// File: rtl/casHomeChk.sv
module casHomeChk #(
  parameter int NUM_NODES  = 4,
  parameter int FAIL_SHARE = 0,
  localparam int NODE_W    = $clog2(NUM_NODES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [NODE_W-1:0] reqNode,
  input logic              rspValid,
  input logic              rspBusy,
  input logic              rspSuccess,
  input logic [1:0]        rspGrant,
  input logic              invValid,
  input logic [NODE_W-1:0] invNode,
  input logic              ackValid
);

  logic              inFlight;
  logic [NODE_W-1:0] ownerReq;
  logic [7:0]        openMsgs;
  logic              newTxn, doneTxn;

  assign newTxn  = reqValid && reqReady && !rspValid;
  assign doneTxn = rspValid && !rspBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      ownerReq <= '0;
      openMsgs <= '0;
    end else begin
      if (newTxn) begin
        inFlight <= 1'b1;
        ownerReq <= reqNode;
      end else if (doneTxn) begin
        inFlight <= 1'b0;
      end
      openMsgs <= openMsgs + 8'(invValid) - 8'(ackValid);
    end
  end

  // R10
  single_txn_chk: assert property (@(posedge clk) disable iff (!rstN)
    newTxn |-> !inFlight);

  // R6
  acks_before_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneTxn && rspSuccess) |-> (openMsgs == 8'd0));

  // R5
  no_self_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (inFlight && invNode != ownerReq));

  // R4
  success_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneTxn && rspSuccess) |-> (rspGrant == 2'd2));

  // R7 R8
  fail_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneTxn && !rspSuccess) |-> (rspGrant == ((FAIL_SHARE != 0) ? 2'd1 : 2'd0)));

  // R9
  busy_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspBusy) |-> (inFlight && !rspSuccess && rspGrant == 2'd0));

endmodule

bind casHomeNode casHomeChk #(
  .NUM_NODES  (NUM_NODES),
  .FAIL_SHARE (FAIL_SHARE)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqNode    (reqNode),
  .rspValid   (rspValid),
  .rspBusy    (rspBusy),
  .rspSuccess (rspSuccess),
  .rspGrant   (rspGrant),
  .invValid   (invValid),
  .invNode    (invNode),
  .ackValid   (ackValid)
);

// File: tb/casHomeNode_tb_top.sv
`timescale 1ns/1ps
module casHomeNode_tb_top;

  localparam int NN = 4;
  localparam int NL = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic          reqValid = 1'b0;
  logic [1:0]    reqNode = '0;
  logic [2:0]    reqLine = '0;
  logic [DW-1:0] reqExpect = '0, reqNew = '0;
  logic          wbValid = 1'b0;
  logic [DW-1:0] wbData = '0;
  logic          ackValid = 1'b0;
  logic          sel = 1'b0;

  logic          reqValidV [2];
  logic          wbValidV  [2];
  logic          ackValidV [2];
  logic          reqReadyV [2];
  logic          rspValidV [2];
  logic          rspBusyV  [2];
  logic          rspSuccV  [2];
  logic [1:0]    rspGrantV [2];
  logic [1:0]    rspNodeV  [2];
  logic [DW-1:0] rspOldV   [2];
  logic          fetchVV   [2];
  logic [1:0]    fetchNodeV[2];
  logic [2:0]    fetchLineV[2];
  logic          invVV     [2];
  logic [1:0]    invNodeV  [2];
  logic [2:0]    invLineV  [2];
  logic          invDownV  [2];

  assign reqValidV[0] = reqValid && !sel;
  assign reqValidV[1] = reqValid && sel;
  assign wbValidV[0]  = wbValid && !sel;
  assign wbValidV[1]  = wbValid && sel;
  assign ackValidV[0] = ackValid && !sel;
  assign ackValidV[1] = ackValid && sel;

  casHomeNode #(.NUM_NODES(NN), .NUM_LINES(NL), .DATA_W(DW), .FAIL_SHARE(0)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValidV[0]), .reqReady(reqReadyV[0]),
    .reqNode(reqNode), .reqLine(reqLine), .reqExpect(reqExpect), .reqNew(reqNew),
    .rspValid(rspValidV[0]), .rspBusy(rspBusyV[0]), .rspSuccess(rspSuccV[0]),
    .rspGrant(rspGrantV[0]), .rspNode(rspNodeV[0]), .rspOld(rspOldV[0]),
    .fetchValid(fetchVV[0]), .fetchNode(fetchNodeV[0]), .fetchLine(fetchLineV[0]),
    .wbValid(wbValidV[0]), .wbData(wbData), .invValid(invVV[0]), .invNode(invNodeV[0]),
    .invLine(invLineV[0]), .invDowngrade(invDownV[0]), .ackValid(ackValidV[0]));

  casHomeNode #(.NUM_NODES(NN), .NUM_LINES(NL), .DATA_W(DW), .FAIL_SHARE(1)) dutShr_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValidV[1]), .reqReady(reqReadyV[1]),
    .reqNode(reqNode), .reqLine(reqLine), .reqExpect(reqExpect), .reqNew(reqNew),
    .rspValid(rspValidV[1]), .rspBusy(rspBusyV[1]), .rspSuccess(rspSuccV[1]),
    .rspGrant(rspGrantV[1]), .rspNode(rspNodeV[1]), .rspOld(rspOldV[1]),
    .fetchValid(fetchVV[1]), .fetchNode(fetchNodeV[1]), .fetchLine(fetchLineV[1]),
    .wbValid(wbValidV[1]), .wbData(wbData), .invValid(invVV[1]), .invNode(invNodeV[1]),
    .invLine(invLineV[1]), .invDowngrade(invDownV[1]), .ackValid(ackValidV[1]));

  int errors = 0;
  int checks = 0;

  // reference directory per mode: state 0 uncached, 1 shared, 2 exclusive
  int         mSt    [2][NL];
  logic [3:0] mMask  [2][NL];
  int         mVal   [2][NL];
  int         ownVal [2][NL];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic checkQuiet(input string req);
    chk(reqReadyV[sel] == 1'b1, req, "reqReady idle", int'(reqReadyV[sel]), 1);
    chk(rspValidV[sel] == 1'b0, req, "rspValid idle", int'(rspValidV[sel]), 0);
    chk(invVV[sel] == 1'b0, req, "invValid idle", int'(invVV[sel]), 0);
    chk(fetchVV[sel] == 1'b0, req, "fetchValid idle", int'(fetchVV[sel]), 0);
  endtask

  task automatic runCas(input int node, input int line, input int expv,
                        input int newv, input bit probe);
    int m = int'(sel);
    bit wasExc = (mSt[m][line] == 2);
    int cur = wasExc ? ownVal[m][line] : mVal[m][line];
    bit match = (cur == expv);
    logic [3:0] reqBit = 4'(1) << node;
    int owner = 0;
    logic [3:0] expInv;
    bit expDown;
    int expGrant;
    bit fetchPending = wasExc;
    int wbCnt = -1;
    int ackQ[$];
    int acksOut = 0;
    bit done = 0;
    int cyc = 0;
    int probeStage = 0;

    for (int i = 0; i < NN; i++) if (mMask[m][line][i]) owner = i;
    if (match) begin
      expInv = mMask[m][line] & ~reqBit; expDown = 0; expGrant = 2;
    end else if (m == 1) begin
      expInv = wasExc ? mMask[m][line] : 4'b0; expDown = 1; expGrant = 1;
    end else begin
      expInv = 4'b0; expDown = 0; expGrant = 0;
    end

    @(negedge clk);
    chk(reqReadyV[sel] == 1'b1, "R10", "ready before request", int'(reqReadyV[sel]), 1);
    reqValid = 1'b1; reqNode = 2'(node); reqLine = 3'(line);
    reqExpect = DW'(expv); reqNew = DW'(newv);
    @(posedge clk);
    #1 reqValid = 1'b0;
    @(negedge clk);

    while (!done && cyc < 200) begin
      // compare observed outputs with the model
      if (probeStage == 1) begin
        chk(rspValidV[sel] && rspBusyV[sel], "R9", "busy response", int'(rspBusyV[sel]), 1);
        chk(rspSuccV[sel] == 1'b0 && rspGrantV[sel] == 2'd0, "R9", "busy grant",
            int'(rspGrantV[sel]), 0);
        chk(int'(rspNodeV[sel]) == (node ^ 1), "R9", "busy node", int'(rspNodeV[sel]), node ^ 1);
      end else if (probeStage == 2) begin
        chk(reqReadyV[sel] == 1'b0, "R10", "other line held off", int'(reqReadyV[sel]), 0);
      end else begin
        chk(!(rspValidV[sel] && rspBusyV[sel]), "R9", "stray busy", 1, 0);
      end
      if (fetchVV[sel]) begin
        chk(fetchPending && int'(fetchNodeV[sel]) == owner && int'(fetchLineV[sel]) == line,
            "R3", "fetch-back target", int'(fetchNodeV[sel]), owner);
        fetchPending = 0;
        wbCnt = 4;
      end
      if (invVV[sel]) begin
        chk(expInv[invNodeV[sel]] == 1'b1 && int'(invLineV[sel]) == line,
            match ? "R5" : (m == 1 ? "R8" : "R7"), "message target",
            int'(invNodeV[sel]), int'(expInv));
        chk(invDownV[sel] == expDown, match ? "R5" : "R8", "downgrade flag",
            int'(invDownV[sel]), int'(expDown));
        expInv[invNodeV[sel]] = 1'b0;
        ackQ.push_back(cyc + 2);
        acksOut++;
      end
      if (rspValidV[sel] && !rspBusyV[sel]) begin
        chk(expInv == 4'b0 && acksOut == 0 && !fetchPending && wbCnt < 0, "R6",
            "response before acks", acksOut, 0);
        chk(rspSuccV[sel] == match, match ? "R4" : (m == 1 ? "R8" : "R7"), "success flag",
            int'(rspSuccV[sel]), int'(match));
        chk(int'(rspGrantV[sel]) == expGrant, match ? "R4" : (m == 1 ? "R8" : "R7"),
            "grant", int'(rspGrantV[sel]), expGrant);
        chk(int'(rspOldV[sel]) == cur, wasExc ? "R3" : "R2", "old value",
            int'(rspOldV[sel]), cur);
        chk(int'(rspNodeV[sel]) == node, "R4", "response node", int'(rspNodeV[sel]), node);
        done = 1;
      end

      // drive the next cycle
      reqValid = 1'b0; wbValid = 1'b0; ackValid = 1'b0;
      if (wbCnt == 1) begin
        wbValid = 1'b1; wbData = DW'(ownVal[m][line]); wbCnt = -1;
      end else if (wbCnt > 1) begin
        wbCnt--;
      end
      if (ackQ.size() > 0 && ackQ[0] <= cyc) begin
        ackValid = 1'b1;
        void'(ackQ.pop_front());
        acksOut--;
      end
      if (probe && wasExc && probeStage == 0 && wbCnt >= 3) begin
        reqValid = 1'b1; reqNode = 2'(node ^ 1); reqLine = 3'(line);
        reqExpect = DW'(cur); reqNew = DW'(16'hdead);
        probeStage = 1;
      end else if (probeStage == 1) begin
        reqValid = 1'b1; reqNode = 2'(node ^ 1); reqLine = 3'((line + 1) % NL);
        probeStage = 2;
      end else if (probeStage == 2) begin
        probeStage = 3;
      end
      cyc++;
      @(negedge clk);
    end
    if (!done) chk(1'b0, "R6", "response timeout", cyc, 0);
    reqValid = 1'b0; wbValid = 1'b0; ackValid = 1'b0;

    if (match) begin
      mSt[m][line] = 2; mMask[m][line] = reqBit; ownVal[m][line] = newv; mVal[m][line] = newv;
    end else if (m == 1) begin
      if (wasExc) mVal[m][line] = cur;
      mSt[m][line] = 1; mMask[m][line] = mMask[m][line] | reqBit;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < NL; l++) begin
        mSt[m][l] = 0; mMask[m][l] = '0; mVal[m][l] = 0; ownVal[m][l] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    sel = 1'b0; checkQuiet("R1");
    sel = 1'b1; checkQuiet("R1");

    // deny mode
    sel = 1'b0;
    runCas(0, 1, 0, 5, 0);   // R1 R2 R4: fresh line holds zero
    runCas(1, 1, 9, 7, 1);   // R3 R7 R9 R10: owner data mismatch, denied
    runCas(2, 1, 5, 8, 0);   // R3 R5: owner invalidated on match
    runCas(3, 3, 4, 1, 0);   // R2 R7: home mismatch
    runCas(3, 3, 0, 1, 0);   // R7: line unchanged after denial
    @(negedge clk);
    checkQuiet("R10");

    // share mode
    sel = 1'b1;
    runCas(0, 1, 0, 5, 0);   // R4
    runCas(1, 1, 9, 7, 1);   // R8 R9 R10: owner downgraded
    runCas(2, 1, 3, 4, 0);   // R2 R8: home value is owner data
    runCas(1, 1, 5, 6, 0);   // R5 R6: two others invalidated
    runCas(3, 4, 1, 2, 0);   // R8: uncached mismatch adds sharer
    runCas(0, 4, 0, 9, 0);   // R5 R6
    runCas(2, 4, 9, 11, 1);  // R3 R5 R9
    runCas(3, 4, 11, 12, 0); // R3 R5
    @(negedge clk);
    checkQuiet("R10");
    finishRun();
  end

endmodule